// File: doc/BRIEF.md
# Reset Release Sequencer with Configuration Straps

This block turns an asynchronous, active-low board reset pin into a timed release of the chip's internal reset. The pin first passes through a synchronizer. When the synchronized reset goes high, the block latches three configuration straps:

- a clock-source select,
- a parallel/host pin-mux mode,
- a serial-port pin-mux mode.

It then counts reference clock cycles. The oscillator settling window applies only when the clock-source strap was latched low, meaning the internal crystal oscillator is used. The propagation window always applies.

When the count ends, the block does four things on the same edge:

- it releases internal reset;
- it lets program flow start;
- it turns on the chip's output drivers;
- it samples the three boot-mode pins into a held register.

The acknowledge output then goes low for a short, fixed pulse.

The block also has a wake path. When the core is running and the oscillator returns from power-down, a wake request holds program flow for one oscillator settling window. Internal reset, the drivers and the acknowledge pulse are not touched on this path. All pins are plain control and status signals. No part of the block carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rstseq_top`

## Requirements
- R1: While the reset pin is low, and until the synchronized reset is seen high, the outputs hold these values: `core_rst_n`=0, `cpu_run`=0, `pad_oe`=0, `ack_n`=1 and `pll_bypass`=1. In the same period `clk_mode` follows `strap_clksel` live.
- R2: The reset pin passes through two flops, which assert asynchronously and release synchronously. Straps are sampled on the third rising clock edge after the pin rises.
- R3: `pmux_mode` and `smux_mode` take the values of `strap_pmux` and `strap_smux` on the strap-sampling edge. They then hold, whatever the straps do, until the next reset.
- R4: `clk_mode` takes `strap_clksel` on the strap-sampling edge and then holds. 0 means the internal oscillator; 1 means the external clock pin.
- R5: With `clk_mode`=0, internal reset is released OSC_CYCLES+PROP_CYCLES cycles after the strap-sampling edge. With the defaults that is 41,102 cycles.
- R6: With `clk_mode`=1, internal reset is released PROP_CYCLES cycles after the strap-sampling edge. With the defaults that is 70 cycles.
- R7: `ack_n` goes low on the release edge and stays low for exactly ACK_CYCLES (2) cycles.
- R8: `boot_mode` takes `boot_pins` on the release edge. It ignores later changes on `boot_pins`.
- R9: `pad_oe` goes high on the release edge, together with `core_rst_n` and `cpu_run`.
- R10: Driving the reset pin low during counting aborts the sequence. The next rise restarts it from the beginning with freshly latched straps.
- R11: In the running state, a high `osc_wake` drops `cpu_run` for exactly OSC_CYCLES cycles. During that time `core_rst_n`, `pad_oe` and `ack_n` stay high, and the strap fields keep their values.
- R12: `osc_wake` is ignored while the release sequence is counting. It does not change the release time, and no wake window follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_pin_n | input | 1 | Asynchronous active-low board reset |
| strap_clksel | input | 1 | Clock source strap (0 = oscillator) |
| strap_pmux | input | 1 | Parallel/host mux strap |
| strap_smux | input | 1 | Serial-port mux strap |
| boot_pins | input | 3 | Boot-mode pins |
| osc_wake | input | 1 | Oscillator power-down wake request |
| core_rst_n | output | 1 | Internal reset, active low |
| cpu_run | output | 1 | Program flow permitted |
| ack_n | output | 1 | Active-low release acknowledge pulse |
| pad_oe | output | 1 | Output driver enable |
| pll_bypass | output | 1 | Clock generator bypass request |
| clk_mode | output | 1 | Latched clock-source mode |
| pmux_mode | output | 1 | Latched parallel/host mux mode |
| smux_mode | output | 1 | Latched serial-port mux mode |
| boot_mode | output | 3 | Captured boot mode |

## Verification
The hardest situation to reach from the ports is a reset that arrives partway through the oscillator window. In that case the restarted sequence must use the new straps and not the stale ones. The bench releases reset with the oscillator strap, waits a few cycles into counting, and pulls the pin low again with every strap changed. It then checks the shorter delay and the new strap values. A wake request pulsed in the middle of the propagation window is also applied, to show that it leaves no trace.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_OSC  = 3'd1,
    ST_PROP = 3'd2,
    ST_RUN  = 3'd3,
    ST_WAKE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= 1'b1;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rel_sync = chain[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int OSC_CYCLES  = 41032,
  parameter int PROP_CYCLES = 70
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rel_sync,
  input  logic clksel_pin,
  input  logic osc_wake,
  output logic in_hold,
  output logic released,
  output logic running,
  output logic latch_stb,
  output logic release_stb
);
  localparam int CNT_W = $clog2(OSC_CYCLES + PROP_CYCLES + 1);
  localparam logic [CNT_W-1:0] OSC_LAST  = CNT_W'(OSC_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROP_LAST = CNT_W'(PROP_CYCLES - 1);

  seq_state_e state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        ST_HOLD: if (rel_sync) begin
          cnt   <= '0;
          state <= clksel_pin ? ST_PROP : ST_OSC;
        end
        ST_OSC: if (cnt == OSC_LAST) begin
          cnt <= '0; state <= ST_PROP;
        end else cnt <= cnt + 1'b1;
        ST_PROP: if (cnt == PROP_LAST) begin
          cnt <= '0; state <= ST_RUN;
        end else cnt <= cnt + 1'b1;
        ST_RUN: if (osc_wake) begin
          cnt <= '0; state <= ST_WAKE;
        end
        ST_WAKE: if (cnt == OSC_LAST) begin
          cnt <= '0; state <= ST_RUN;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign in_hold     = (state == ST_HOLD);
  assign released    = (state == ST_RUN) || (state == ST_WAKE);
  assign running     = (state == ST_RUN);
  assign latch_stb   = in_hold && rel_sync;
  assign release_stb = (state == ST_PROP) && (cnt == PROP_LAST);

  // R5: the oscillator and wake windows never run past their length
  p_osc_bound_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_OSC || state == ST_WAKE) |-> cnt <= OSC_LAST);
  // R12: a wake request during counting never opens a wake window
  p_wake_ignored_r12: assert property (@(posedge clk) disable iff (!arst_n)
    ((state == ST_OSC || state == ST_PROP) && osc_wake) |=> state != ST_WAKE);
  // R11: a wake window always comes from the running state
  p_wake_from_run_r11: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(state == ST_WAKE) |-> $past(state) == ST_RUN);
endmodule

// File: rtl/rstseq_straps.sv
module rstseq_straps #(
  parameter int BOOT_W = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              latch_stb,
  input  logic              release_stb,
  input  logic              clksel_pin,
  input  logic              pmux_pin,
  input  logic              smux_pin,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic              clkm_q,
  output logic              pmux_q,
  output logic              smux_q,
  output logic [BOOT_W-1:0] boot_q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      clkm_q <= 1'b0;
      pmux_q <= 1'b0;
      smux_q <= 1'b0;
      boot_q <= '0;
    end else begin
      if (latch_stb) begin
        clkm_q <= clksel_pin;
        pmux_q <= pmux_pin;
        smux_q <= smux_pin;
      end
      if (release_stb) boot_q <= boot_pins;
    end
  end

  // R3/R4: strap fields only move on the sampling strobe
  p_straps_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !latch_stb |=> $stable({clkm_q, pmux_q, smux_q}));
  // R8: boot field only moves on the release strobe
  p_boot_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
    !release_stb |=> $stable(boot_q));
endmodule

// File: rtl/rstseq_ack.sv
module rstseq_ack #(
  parameter int ACK_CYCLES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic release_stb,
  output logic ack_n
);
  localparam int ACK_W = $clog2(ACK_CYCLES + 1);
  logic [ACK_W-1:0] left;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) left <= '0;
    else if (release_stb) left <= ACK_W'(ACK_CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

  assign ack_n = (left == '0);

  // R7: once low, the pulse lasts at least two cycles
  p_ack_min_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(ack_n) |=> !ack_n);
  // R7: the pulse ends after its second low cycle when not re-armed
  p_ack_max_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (!ack_n && $past(!ack_n) && !release_stb) |=> ack_n);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int OSC_CYCLES  = 41032,
  parameter int PROP_CYCLES = 70,
  parameter int ACK_CYCLES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       strap_clksel,
  input  logic       strap_pmux,
  input  logic       strap_smux,
  input  logic [2:0] boot_pins,
  input  logic       osc_wake,
  output logic       core_rst_n,
  output logic       cpu_run,
  output logic       ack_n,
  output logic       pad_oe,
  output logic       pll_bypass,
  output logic       clk_mode,
  output logic       pmux_mode,
  output logic       smux_mode,
  output logic [2:0] boot_mode
);
  logic rel_sync, in_hold, released, running, latch_stb, release_stb, clkm_q;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_pin_n), .rel_sync(rel_sync));

  rstseq_fsm #(.OSC_CYCLES(OSC_CYCLES), .PROP_CYCLES(PROP_CYCLES)) u_fsm (
    .clk(clk), .arst_n(rst_pin_n), .rel_sync(rel_sync),
    .clksel_pin(strap_clksel), .osc_wake(osc_wake), .in_hold(in_hold),
    .released(released), .running(running), .latch_stb(latch_stb),
    .release_stb(release_stb));

  rstseq_straps #(.BOOT_W(3)) u_straps (
    .clk(clk), .arst_n(rst_pin_n), .latch_stb(latch_stb),
    .release_stb(release_stb), .clksel_pin(strap_clksel),
    .pmux_pin(strap_pmux), .smux_pin(strap_smux), .boot_pins(boot_pins),
    .clkm_q(clkm_q), .pmux_q(pmux_mode), .smux_q(smux_mode),
    .boot_q(boot_mode));

  rstseq_ack #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
    .clk(clk), .arst_n(rst_pin_n), .release_stb(release_stb), .ack_n(ack_n));

  assign core_rst_n = released;
  assign pad_oe     = released;
  assign cpu_run    = running;
  assign pll_bypass = in_hold;
  assign clk_mode   = in_hold ? strap_clksel : clkm_q;

  // R7: acknowledge is low in the first released cycle
  p_ack_at_release_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(core_rst_n) |-> !ack_n);
  // R9: drivers come on only together with program flow
  p_oe_with_run_r9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(pad_oe) |-> cpu_run);
endmodule

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;
  localparam int O = 20;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic strap_clksel = 1'b0, strap_pmux = 1'b0, strap_smux = 1'b0;
  logic [2:0] boot_pins = 3'd0;
  logic osc_wake = 1'b0;
  logic core_rst_n, cpu_run, ack_n, pad_oe, pll_bypass;
  logic clk_mode, pmux_mode, smux_mode;
  logic [2:0] boot_mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rstseq_top #(.OSC_CYCLES(O), .PROP_CYCLES(P)) dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .strap_clksel(strap_clksel),
    .strap_pmux(strap_pmux), .strap_smux(strap_smux), .boot_pins(boot_pins),
    .osc_wake(osc_wake), .core_rst_n(core_rst_n), .cpu_run(cpu_run),
    .ack_n(ack_n), .pad_oe(pad_oe), .pll_bypass(pll_bypass),
    .clk_mode(clk_mode), .pmux_mode(pmux_mode), .smux_mode(smux_mode),
    .boot_mode(boot_mode));

  // Vector fields: {clksel, pmux, smux, boot[2:0]}
  localparam logic [5:0] VEC [6] = '{
    6'b0_0_0_000, 6'b1_0_0_101, 6'b0_1_0_011,
    6'b1_1_1_111, 6'b0_0_1_110, 6'b1_1_0_001 };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [5:0] v);
    int n;
    int expd;
    @(negedge clk);
    rst_pin_n = 1'b0;
    {strap_clksel, strap_pmux, strap_smux, boot_pins} = v;
    repeat (3) @(negedge clk);
    chk(!core_rst_n && !cpu_run && !pad_oe && ack_n && pll_bypass, "R1 hold outputs",
        {core_rst_n, cpu_run, pad_oe, ack_n, pll_bypass}, 5'b00011);
    chk(clk_mode == v[5], "R1 clk_mode live", clk_mode, v[5]);
    rst_pin_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!core_rst_n && n < 500);
    expd = 3 + (v[5] ? 0 : O) + P;
    chk(n == expd, v[5] ? "R6/R2 release delay ext clock" : "R5/R2 release delay oscillator",
        n, expd);
    chk(pad_oe && cpu_run, "R9 drivers on at release", {pad_oe, cpu_run}, 2'b11);
    chk(!ack_n, "R7 ack low cycle 1", ack_n, 0);
    chk(boot_mode == v[2:0], "R8 boot capture", boot_mode, v[2:0]);
    chk({clk_mode, pmux_mode, smux_mode} == v[5:3], "R3/R4 strap latch",
        {clk_mode, pmux_mode, smux_mode}, v[5:3]);
    boot_pins = ~v[2:0];
    strap_clksel = ~v[5];
    strap_pmux = ~v[4];
    @(negedge clk);
    chk(!ack_n, "R7 ack low cycle 2", ack_n, 0);
    @(negedge clk);
    chk(ack_n, "R7 ack ends", ack_n, 1);
    chk(boot_mode == v[2:0], "R8 boot ignores later pins", boot_mode, v[2:0]);
    chk({clk_mode, pmux_mode} == v[5:4], "R3/R4 straps hold", {clk_mode, pmux_mode}, v[5:4]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    // R1 live clock mode follow during reset
    repeat (2) @(negedge clk);
    strap_clksel = 1'b1;
    @(negedge clk);
    chk(clk_mode == 1'b1 && pll_bypass, "R1 follow high", clk_mode, 1);
    strap_clksel = 1'b0;
    @(negedge clk);
    chk(clk_mode == 1'b0, "R1 follow low", clk_mode, 0);

    foreach (VEC[i]) run_seq(VEC[i]);

    // R10: abort during the oscillator window, restart with new straps
    @(negedge clk);
    rst_pin_n = 1'b0;
    {strap_clksel, strap_pmux, strap_smux, boot_pins} = 6'b0_0_0_000;
    repeat (2) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!core_rst_n, "R10 still counting", core_rst_n, 0);
    run_seq(6'b1_1_1_010);
    chk(pmux_mode && smux_mode, "R10 restarted straps", {pmux_mode, smux_mode}, 2'b11);

    // R11: wake window while running
    strap_smux = 1'b0;
    @(negedge clk);
    osc_wake = 1'b1;
    n = 0;
    bad = 0;
    do begin
      @(negedge clk);
      osc_wake = 1'b0;
      n++;
      if (!core_rst_n || !pad_oe || !ack_n) bad++;
    end while (!cpu_run && n < 500);
    chk(n == O + 1, "R11 wake window length", n - 1, O);
    chk(bad == 0, "R11 release held during wake", bad, 0);
    chk(smux_mode == 1'b1, "R11 straps unchanged by wake", smux_mode, 1);

    // R12: wake request during propagation count is ignored
    @(negedge clk);
    rst_pin_n = 1'b0;
    {strap_clksel, strap_pmux, strap_smux, boot_pins} = 6'b1_0_0_100;
    repeat (2) @(negedge clk);
    rst_pin_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      osc_wake = (n == 5);
    end while (!core_rst_n && n < 500);
    osc_wake = 1'b0;
    chk(n == 3 + P, "R12 release time unchanged", n, 3 + P);
    bad = 0;
    repeat (O + 4) begin
      @(negedge clk);
      if (!cpu_run) bad++;
    end
    chk(bad == 0, "R12 no wake window follows", bad, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule